// File: doc/BRIEF.md
# Differential Clock Gate and Power-Down Sequencer

This block sits between a reference clock and a bank of differential clock output drivers. It produces fifteen gated clock outputs and one feedback output, each as a true/complement pair. Each of the fifteen outputs can be switched off by its own enable bit from the register block. All sixteen outputs, the feedback pair included, are stopped by an asynchronous active-low power-down line. Every stopped output rests with both legs low and never emits a shortened pulse.

The power-down line and the enable vector are brought into the reference clock domain through a chain of rising-edge flops. The gate of each output then changes only on a falling edge of the clock. The true leg is low at that moment, so it cannot be cut short. Once every output has stopped, a "PLL off" flag asserts on the next rising edge. On release, the flag drops before the first output restarts.

Top module: `diffclk_gate_seq`

## Requirements
- R1: While reset is asserted and until the first restart after it, every true and complement leg, including the feedback pair, is low and `pll_off` is high. The enable synchroniser resets to all ones, meaning every output is enabled.
- R2: When an output is running, its true leg equals the reference clock and its complement leg is the exact inverse of the true leg.
- R3: If `pd_n` is sampled low at rising edge k and again at rising edge k+1, then from the falling edge that follows edge k+1 both legs of all outputs, the feedback pair included, are low. They stay low while the sampled value remains low.
- R4: An enable bit at 0 stops its output with both legs low. A change on `out_en[i]` is sampled on two rising edges and takes effect on the falling edge after the second one, with the same latency as R3.
- R5: The feedback pair ignores `out_en`. It runs whenever the synchronised power-down is high, even with every enable bit at 0.
- R6: `pll_off` rises on the first rising edge after all outputs have stopped. It is never high while any output gate is open.
- R7: After `pd_n` is sampled high at rising edge k, `pll_off` drops at edge k+1. Enabled outputs restart at the falling edge after k+1: the complement leg goes high first, and the true leg first rises at edge k+2.
- R8: Every high phase of every true leg lasts exactly half a clock period, under any sequence of enable and power-down changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that is gated onto the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| out_en | input | NUM_OUT (15) | Per-output enable bits, 1 = run |
| clk_t | output | NUM_OUT (15) | True legs of the gated outputs |
| clk_c | output | NUM_OUT (15) | Complement legs of the gated outputs |
| fb_t | output | 1 | True leg of the feedback output |
| fb_c | output | 1 | Complement leg of the feedback output |
| pll_off | output | 1 | High when all clocks are stopped and the loop may be turned off |

## Verification
A gate flop that loads at the wrong edge shows up at the ports within one clock period. It appears either as a true-leg high phase shorter than half a period, or as a leg that is high or low in the wrong quarter of the cycle. A synchroniser with the wrong depth, or with the wrong reset value, shifts the stop and restart points by whole cycles. The cycle-accurate reference exposes that within two cycles of any power-down or enable change. A wrong `pll_off` state is visible on the first rising edge after a stop or release, as the flag lagging or leading the gates.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/100ps
package clkgate_pkg;
   // default bank size and synchroniser depth
   localparam int unsigned DEF_NUM_OUT     = 15;
   localparam int unsigned MAX_NUM_OUT     = 64;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // one differential output
   typedef struct packed {
      logic t;
      logic c;
   } diff_pair_t;
endpackage

// File: rtl/cg_sync_chain.sv
`timescale 1ns/100ps
module cg_sync_chain #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_BIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int unsigned   LAST    = STAGES - 1;
   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

   if (STAGES < 2) begin : g_bad_depth
      $error("cg_sync_chain needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cg_sync_chain needs a non-zero width");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VEC;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VEC;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[LAST];
endmodule

// File: rtl/cg_lane.sv
`timescale 1ns/100ps
module cg_lane
   import clkgate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,    // synchronised power-down release
   input  logic       en_i,     // synchronised enable bit
   output logic       gate_o,
   output diff_pair_t pair_o
);
   logic gate_q;

   // gate moves only while the clock is low: no truncated high phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= run_i & en_i;
   end

   assign gate_o   = gate_q;
   assign pair_o.t = clk & gate_q;
   assign pair_o.c = ~clk & gate_q;

   // R3: a low run request closes the gate at the next falling edge
   p_lane_stop_r3: assert property (@(negedge clk) disable iff (!rst_n)
      !run_i |=> !gate_q);

   // R4: an enabled lane with run high is open after the falling edge
   p_lane_open_r4: assert property (@(negedge clk) disable iff (!rst_n)
      (run_i && en_i) |=> gate_q);

   // R4: a cleared enable closes the gate at the next falling edge
   p_lane_en_off_r4: assert property (@(negedge clk) disable iff (!rst_n)
      !en_i |=> !gate_q);
endmodule

// File: rtl/diffclk_gate_seq.sv
`timescale 1ns/100ps
module diffclk_gate_seq
   import clkgate_pkg::*;
#(
   parameter int unsigned NUM_OUT     = DEF_NUM_OUT,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic               pd_n,
   input  logic [NUM_OUT-1:0] out_en,
   output logic [NUM_OUT-1:0] clk_t,
   output logic [NUM_OUT-1:0] clk_c,
   output logic               fb_t,
   output logic               fb_c,
   output logic               pll_off
);
   localparam logic [NUM_OUT-1:0] NONE_OPEN = '0;

   if (NUM_OUT == 0 || NUM_OUT > MAX_NUM_OUT) begin : g_bad_count
      $error("diffclk_gate_seq: NUM_OUT out of range");
   end

   logic               pd_sync;
   logic [NUM_OUT-1:0] en_sync;
   logic [NUM_OUT-1:0] lane_gate;
   logic               fb_gate;
   diff_pair_t         fb_pair;
   logic               pll_q;

   // power-down: resets to "down" so outputs start only after release
   cg_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_pd_sync (
      .clk  (ref_clk),
      .rst_n(rst_n),
      .d_i  (pd_n),
      .q_o  (pd_sync)
   );

   // enables: reset to all enabled
   cg_sync_chain #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_en_sync (
      .clk  (ref_clk),
      .rst_n(rst_n),
      .d_i  (out_en),
      .q_o  (en_sync)
   );

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      diff_pair_t pair;
      cg_lane u_lane (
         .clk   (ref_clk),
         .rst_n (rst_n),
         .run_i (pd_sync),
         .en_i  (en_sync[i]),
         .gate_o(lane_gate[i]),
         .pair_o(pair)
      );
      assign clk_t[i] = pair.t;
      assign clk_c[i] = pair.c;
   end

   // feedback lane has no enable bit
   cg_lane u_fb_lane (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .run_i (pd_sync),
      .en_i  (1'b1),
      .gate_o(fb_gate),
      .pair_o(fb_pair)
   );
   assign fb_t = fb_pair.t;
   assign fb_c = fb_pair.c;

   // off flag is set one rising edge after the stop has been applied,
   // and cleared as soon as the release is seen, ahead of the restart
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) pll_q <= 1'b1;
      else        pll_q <= ~fb_gate;
   end
   assign pll_off = pll_q & ~pd_sync;

   // R3: a synchronised stop closes every gate at the next falling edge
   p_stop_all_r3: assert property (@(negedge ref_clk) disable iff (!rst_n)
      !pd_sync |=> (lane_gate == NONE_OPEN && !fb_gate));

   // R5: feedback runs whenever power-down is released, regardless of enables
   p_fb_free_r5: assert property (@(negedge ref_clk) disable iff (!rst_n)
      pd_sync |=> fb_gate);

   // R6: the off flag never coexists with an open gate
   p_off_after_gates_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      pll_off |-> (lane_gate == NONE_OPEN && !fb_gate));

   // R7: the off flag is low once the release has been synchronised
   p_off_clear_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(pd_sync) |-> !pll_off);
endmodule

// File: tb/diffclk_gate_seq_tb.sv
`timescale 1ns/100ps
module diffclk_gate_seq_tb;
   localparam realtime CLK_PERIOD = 10.0;
   localparam realtime HALF = CLK_PERIOD / 2.0;
   localparam realtime QTR  = CLK_PERIOD / 4.0;
   localparam int      N    = 15;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pd_n = 1'b1;
   logic [N-1:0] en = '1;
   logic [N-1:0] clk_t, clk_c;
   logic         fb_t, fb_c, pll_off;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   diffclk_gate_seq u_dut (
      .ref_clk(clk), .rst_n(rst_n), .pd_n(pd_n), .out_en(en),
      .clk_t(clk_t), .clk_c(clk_c), .fb_t(fb_t), .fb_c(fb_c), .pll_off(pll_off)
   );

   always #(HALF) clk = ~clk;

   // reference model built from the requirements
   logic         ps1, ps2, pllq_x, fb_x;
   logic [N-1:0] es1, es2, g_x;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps1 = 1'b0; ps2 = 1'b0; es1 = '1; es2 = '1; pllq_x = 1'b1;
      end else begin
         pllq_x = !fb_x;
         ps2 = ps1; ps1 = pd_n;
         es2 = es1; es1 = en;
      end
   end

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_x = '0; fb_x = 1'b0;
      end else begin
         g_x  = ps2 ? es2 : '0;
         fb_x = ps2;
      end
   end

   function automatic logic pll_exp();
      return pllq_x & !ps2;
   endfunction

   function automatic string out_tag();
      if (!ps2)       return "R3";
      else if (es2 != '1) return "R4";
      else            return "R2";
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // R8: every true-leg high phase is exactly half a period
   realtime rise_t [N+1];
   logic [N:0] prev_t = '0;
   always @(clk_t or fb_t) begin
      for (int i = 0; i <= N; i++) begin
         logic cur;
         cur = (i == N) ? fb_t : clk_t[i];
         if (cur && !prev_t[i]) rise_t[i] = $realtime;
         else if (!cur && prev_t[i] && rst_n) begin
            realtime w;
            w = $realtime - rise_t[i];
            chk((w > HALF - 0.05) && (w < HALF + 0.05), "R8", "high phase width (x10ps)",
                32'(int'(w * 100.0)), 32'(int'(HALF * 100.0)));
         end
         prev_t[i] = cur;
      end
   end

   logic [N-1:0] hi_t;
   logic         hi_pll;
   logic [N-1:0] lo_c;
   logic         lo_fbc;

   // one cycle: drive now (just after a falling edge), check both phases
   task automatic run_cycle(input logic pdv, input logic [N-1:0] env);
      pd_n = pdv;
      en   = env;
      @(posedge clk); #(QTR);
      hi_t = clk_t; hi_pll = pll_off;
      chk(clk_t == g_x, out_tag(), "clk_t high phase", 32'(clk_t), 32'(g_x));
      chk(clk_c == '0, "R2", "clk_c high phase", 32'(clk_c), 32'd0);
      chk(fb_t == fb_x && fb_c == 1'b0, "R5", "fb high phase", {30'd0, fb_t, fb_c}, {30'd0, fb_x, 1'b0});
      chk(pll_off == pll_exp(), pll_exp() ? "R6" : "R7", "pll_off", 32'(pll_off), 32'(pll_exp()));
      @(negedge clk); #(QTR);
      lo_c = clk_c; lo_fbc = fb_c;
      chk(clk_c == g_x, out_tag(), "clk_c low phase", 32'(clk_c), 32'(g_x));
      chk(clk_t == '0, "R2", "clk_t low phase", 32'(clk_t), 32'd0);
      chk(fb_c == fb_x && fb_t == 1'b0, "R5", "fb low phase", {30'd0, fb_t, fb_c}, {30'd0, 1'b0, fb_x});
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed_val;
      seed_val = $urandom(32'd20240611);
      for (int i = 0; i <= N; i++) rise_t[i] = 0.0;

      // R1: reset state
      repeat (3) @(negedge clk);
      #(QTR);
      chk(clk_t == '0 && clk_c == '0, "R1", "legs in reset", {1'b0, clk_t, 1'b0, clk_c}, 32'd0);
      chk(fb_t == 1'b0 && fb_c == 1'b0, "R1", "fb in reset", {30'd0, fb_t, fb_c}, 32'd0);
      chk(pll_off == 1'b1, "R1", "pll_off in reset", 32'(pll_off), 32'd1);
      @(negedge clk); #(QTR);
      rst_n = 1'b1;

      // R1: first cycle after reset still stopped
      run_cycle(1'b1, '1);
      chk(hi_t == '0 && hi_pll == 1'b1, "R1", "stopped after reset", {15'd0, hi_pll, 1'b0, hi_t}, 32'h0001_0000);
      chk(lo_c == '0, "R1", "complement stopped after reset", 32'(lo_c), 32'd0);
      repeat (3) run_cycle(1'b1, '1);

      // R7: stop, then release with exact restart timing
      repeat (4) run_cycle(1'b0, '1);
      run_cycle(1'b1, '1);
      chk(hi_pll == 1'b1 && hi_t == '0, "R7", "one sample after release", {15'd0, hi_pll, 1'b0, hi_t}, 32'h0001_0000);
      chk(lo_c == '0, "R7", "complement still low", 32'(lo_c), 32'd0);
      run_cycle(1'b1, '1);
      chk(hi_pll == 1'b0 && hi_t == '0, "R7", "off flag dropped before restart", {15'd0, hi_pll, 1'b0, hi_t}, 32'd0);
      chk(lo_c == '1 && lo_fbc, "R7", "complement restarts first", {15'd0, lo_fbc, 1'b0, lo_c}, {15'd0, 1'b1, 1'b0, 15'h7fff});
      run_cycle(1'b1, '1);
      chk(hi_t == '1, "R7", "first true rising edge", 32'(hi_t), 32'h7fff);

      // R4: one enable dropped, two-sample latency
      run_cycle(1'b1, 15'h7ff7);
      chk(hi_t[3] && lo_c[3], "R4", "bit3 still running", {30'd0, hi_t[3], lo_c[3]}, 32'd3);
      run_cycle(1'b1, 15'h7ff7);
      chk(hi_t[3] && !lo_c[3], "R4", "bit3 stops at falling edge", {30'd0, hi_t[3], lo_c[3]}, 32'd2);
      run_cycle(1'b1, 15'h7ff7);
      chk(!hi_t[3] && hi_t[2], "R4", "bit3 low, neighbour running", {30'd0, hi_t[3], hi_t[2]}, 32'd1);

      // R5: every enable cleared, feedback keeps running
      repeat (3) run_cycle(1'b1, '0);
      chk(lo_c == '0 && lo_fbc, "R5", "feedback ignores enables", {15'd0, lo_fbc, 1'b0, lo_c}, 32'h0001_0000);

      // R3/R8: single-cycle power-down pulse
      run_cycle(1'b1, '1);
      run_cycle(1'b1, '1);
      run_cycle(1'b0, '1);
      repeat (4) run_cycle(1'b1, '1);

      // random enable and power-down toggling
      for (int c = 0; c < 3000; c++) begin
         logic         pdv;
         logic [N-1:0] env;
         pdv = pd_n;
         env = en;
         if ($urandom_range(7) == 0) pdv = ~pd_n;
         if ($urandom_range(3) == 0) env = N'($urandom);
         run_cycle(pdv, env);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule